// File: doc/BRIEF.md
# Cipher Engine Event, Interrupt and DMA Request Unit

This block sits beside a block cipher core and tracks the handshake flags that tell a host, or a DMA engine, when it may act. There are four of them. One shows that the 16-byte input buffer is empty. One shows that a result block is waiting to be read. One shows that the context registers may be rewritten. The last shows that a saved tag or IV is ready to be collected. The four flags form a live event vector. That vector feeds one masked interrupt line and four DMA request lines.

The host programs two registers. The first is a 4-bit interrupt enable register that uses the same layout as the event vector. The second is a configuration word that holds the four DMA request enables and a remap bit. When the remap bit is set, the saved-context event is folded onto the data-out interrupt term and onto the data-out DMA request. The context-out enables then no longer matter.

The cipher core drives its side of the handshakes through single-cycle pulses. The block does not contain the cipher itself.

Top module: `crypt_evt_unit`

## Requirements
- R1: After reset, `evt_status` is 4'b0011 (input buffer empty, context writable). `en_rdata`, `cfg_rdata`, `irq` and `dma_req` are all zero.
- R2: `evt_status` follows the live flags with no latching. Bit 0 is context writable, bit 1 is input buffer empty, bit 2 is result waiting and bit 3 is saved context waiting.
- R3: With remap clear, `irq` is the OR over all bits of `evt_status` AND `en_rdata`.
- R4: With remap clear, each DMA line is held high while its event is present and its enable is set. The enables are config bits 5 to 8. `dma_req[0]` is data in (bit 1 event, config bit 5). `dma_req[1]` is data out (bit 2 event, config bit 6). `dma_req[2]` is context in (bit 0 event, config bit 7). `dma_req[3]` is context out (bit 3 event, config bit 8).
- R5: With config bit 9 set, the data-out interrupt term and `dma_req[1]` use (result waiting OR saved context waiting). `dma_req[3]` and the interrupt term for bit 3 are 0, whatever enable bit 3 and config bit 8 hold.
- R6: A `blk_wr` pulse clears status bit 1 on the next cycle. A `core_take` pulse sets it again. When both arrive in the same cycle, `blk_wr` wins. A `core_take` with the buffer already empty has no effect.
- R7: A `core_out` pulse sets status bit 2. A `blk_rd` pulse clears it. When both arrive in the same cycle, `core_out` wins.
- R8: `ctx_load` while the context is writable clears bit 0 and samples `save_ctx`. The next `op_done` then sets bit 3 if the sample was 1, or bit 0 if it was 0. `ctx_rd` while bit 3 is set clears bit 3 and sets bit 0.
- R9: Status bits 0 and 3 are never 1 together.
- R10: Only config bits 9 to 5 are stored. The other bits of `cfg_rdata` always read 0.
- R11: Three context pulses are ignored: `ctx_load` while an operation is pending or a saved context waits, `op_done` with no operation pending, and `ctx_rd` with no saved context. A `save_ctx` value given with an ignored load is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Write strobe for the interrupt enable register |
| en_wdata | input | 4 | Interrupt enable write data |
| en_rdata | output | 4 | Interrupt enable register value |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 10 | Configuration write data |
| cfg_rdata | output | 10 | Configuration word readback |
| blk_wr | input | 1 | Host has written a full input block |
| core_take | input | 1 | Core has consumed the input block |
| core_out | input | 1 | Core has produced a result block |
| blk_rd | input | 1 | Host has read the result block |
| ctx_load | input | 1 | Host commits a new context |
| save_ctx | input | 1 | Request that the tag/IV be saved when the operation ends |
| op_done | input | 1 | Core has finished the operation |
| ctx_rd | input | 1 | Host has collected the saved tag/IV |
| evt_status | output | 4 | Live event vector |
| irq | output | 1 | Masked interrupt |
| dma_req | output | 4 | DMA request lines |

## Verification
The bench builds the block with its default parameters: a 10-bit configuration word, DMA enables at bits 5 to 8 and remap at bit 9. The enable field is then five bits wide and the interrupt mask four bits wide. That makes a full cross of every mask and configuration value practical. The cross is repeated on each of the twelve reachable flag states, so every remap fold and every gating term is observed at the pins. Directed pulse sequences cover the collisions on the same cycle and the ignored context pulses.

// File: rtl/crypt_evt_pkg.sv
package crypt_evt_pkg;
  localparam int EVT_N   = 4;
  localparam int EV_CIN  = 0;   // context writable
  localparam int EV_DIN  = 1;   // input buffer empty
  localparam int EV_DOUT = 2;   // result waiting
  localparam int EV_COUT = 3;   // saved context waiting

  typedef enum logic [1:0] {CTX_IDLE = 2'd0, CTX_BUSY = 2'd1, CTX_SAVED = 2'd2} ctx_st_e;

  // DMA line d is driven by this event
  function automatic int dma_src(input int d);
    case (d)
      0:       return EV_DIN;
      1:       return EV_DOUT;
      2:       return EV_CIN;
      default: return EV_COUT;
    endcase
  endfunction

  // Remap folds the saved-context event onto the data-out event
  function automatic logic [EVT_N-1:0] fold_evt(input logic [EVT_N-1:0] st, input logic remap);
    logic [EVT_N-1:0] f;
    f = st;
    if (remap) begin
      f[EV_DOUT] = st[EV_DOUT] | st[EV_COUT];
      f[EV_COUT] = 1'b0;
    end
    return f;
  endfunction
endpackage

// File: rtl/crypt_evt_flags.sv
module crypt_evt_flags
  import crypt_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_wr,
  input  logic             core_take,
  input  logic             core_out,
  input  logic             blk_rd,
  input  logic             ctx_load,
  input  logic             save_ctx,
  input  logic             op_done,
  input  logic             ctx_rd,
  output logic [EVT_N-1:0] st
);
  logic    in_full_q, out_q, save_q;
  ctx_st_e ctx_q, ctx_d;
  logic    load_ok;

  assign load_ok = ctx_load && (ctx_q == CTX_IDLE);

  always_comb begin
    ctx_d = ctx_q;
    case (ctx_q)
      CTX_IDLE:  if (ctx_load) ctx_d = CTX_BUSY;
      CTX_BUSY:  if (op_done)  ctx_d = save_q ? CTX_SAVED : CTX_IDLE;
      CTX_SAVED: if (ctx_rd)   ctx_d = CTX_IDLE;
      default:   ctx_d = CTX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full_q <= 1'b0;
      out_q     <= 1'b0;
      save_q    <= 1'b0;
      ctx_q     <= CTX_IDLE;
    end else begin
      in_full_q <= blk_wr | (in_full_q & ~core_take);
      out_q     <= core_out | (out_q & ~blk_rd);
      ctx_q     <= ctx_d;
      if (load_ok) save_q <= save_ctx;
    end
  end

  assign st[EV_CIN]  = (ctx_q == CTX_IDLE);
  assign st[EV_DIN]  = ~in_full_q;
  assign st[EV_DOUT] = out_q;
  assign st[EV_COUT] = (ctx_q == CTX_SAVED);
endmodule

// File: rtl/crypt_evt_regs.sv
module crypt_evt_regs
  import crypt_evt_pkg::*;
#(
  parameter int CFG_W     = 10,
  parameter int DMA_LSB   = 5,
  parameter int REMAP_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [EVT_N-1:0] en_wdata,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [EVT_N-1:0] en_q,
  output logic [CFG_W-1:0] cfg_q
);
  localparam logic [CFG_W-1:0] KEEP =
    CFG_W'(((1 << (REMAP_BIT + 1)) - 1) ^ ((1 << DMA_LSB) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_wdata;
      if (cfg_we) cfg_q <= cfg_wdata & KEEP;
    end
  end
endmodule

// File: rtl/crypt_evt_route.sv
module crypt_evt_route
  import crypt_evt_pkg::*;
#(
  parameter int CFG_W     = 10,
  parameter int DMA_LSB   = 5,
  parameter int REMAP_BIT = 9
) (
  input  logic [EVT_N-1:0] st,
  input  logic [EVT_N-1:0] en,
  input  logic [CFG_W-1:0] cfg,
  output logic [EVT_N-1:0] eff,
  output logic             irq,
  output logic [EVT_N-1:0] dma_req
);
  assign eff = fold_evt(st, cfg[REMAP_BIT]);
  assign irq = |(eff & en);

  for (genvar d = 0; d < EVT_N; d++) begin : g_dma
    localparam int SRC = dma_src(d);
    assign dma_req[d] = eff[SRC] & cfg[DMA_LSB + d];
  end
endmodule

// File: rtl/crypt_evt_unit.sv
module crypt_evt_unit
  import crypt_evt_pkg::*;
#(
  parameter int CFG_W     = 10,
  parameter int DMA_LSB   = 5,
  parameter int REMAP_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [3:0]       en_wdata,
  output logic [3:0]       en_rdata,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             blk_wr,
  input  logic             core_take,
  input  logic             core_out,
  input  logic             blk_rd,
  input  logic             ctx_load,
  input  logic             save_ctx,
  input  logic             op_done,
  input  logic             ctx_rd,
  output logic [3:0]       evt_status,
  output logic             irq,
  output logic [3:0]       dma_req
);
  logic [EVT_N-1:0] st_w, en_w, eff_w;
  logic [CFG_W-1:0] cfg_w;

  crypt_evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .core_take(core_take),
    .core_out(core_out), .blk_rd(blk_rd), .ctx_load(ctx_load),
    .save_ctx(save_ctx), .op_done(op_done), .ctx_rd(ctx_rd), .st(st_w)
  );

  crypt_evt_regs #(.CFG_W(CFG_W), .DMA_LSB(DMA_LSB), .REMAP_BIT(REMAP_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .en_q(en_w), .cfg_q(cfg_w)
  );

  crypt_evt_route #(.CFG_W(CFG_W), .DMA_LSB(DMA_LSB), .REMAP_BIT(REMAP_BIT)) u_route (
    .st(st_w), .en(en_w), .cfg(cfg_w), .eff(eff_w), .irq(irq), .dma_req(dma_req)
  );

  assign evt_status = st_w;
  assign en_rdata   = en_w;
  assign cfg_rdata  = cfg_w;
endmodule

// File: rtl/crypt_evt_chk.sv
module crypt_evt_chk #(
  parameter int CFG_W     = 10,
  parameter int REMAP_BIT = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_wr,
  input logic             core_out,
  input logic             ctx_load,
  input logic             op_done,
  input logic [3:0]       en_rdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [3:0]       evt_status,
  input logic             irq,
  input logic [3:0]       dma_req
);
  // R9
  ctx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_status[0] && evt_status[3]));
  // R6
  in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr |=> !evt_status[1]);
  // R7
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_out |=> evt_status[2]);
  // R8
  ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && evt_status[0]) |=> (!evt_status[0] && !evt_status[3]));
  // R8
  saved_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_status[3]) |-> $past(op_done));
  // R5
  remap_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REMAP_BIT] |-> !dma_req[3]);
  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rdata == 4'd0) |-> !irq);
endmodule

bind crypt_evt_unit crypt_evt_chk #(.CFG_W(CFG_W), .REMAP_BIT(REMAP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .core_out(core_out),
  .ctx_load(ctx_load), .op_done(op_done), .en_rdata(en_rdata),
  .cfg_rdata(cfg_rdata), .evt_status(evt_status), .irq(irq), .dma_req(dma_req)
);

// File: tb/sim_crypt_evt_unit.sv
module sim_crypt_evt_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_we = 0, cfg_we = 0;
  logic [3:0] en_wdata = '0;
  logic [9:0] cfg_wdata = '0;
  logic blk_wr = 0, core_take = 0, core_out = 0, blk_rd = 0;
  logic ctx_load = 0, save_ctx = 0, op_done = 0, ctx_rd = 0;
  logic [3:0] en_rdata, evt_status, dma_req;
  logic [9:0] cfg_rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crypt_evt_unit u0 (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .blk_wr(blk_wr), .core_take(core_take), .core_out(core_out), .blk_rd(blk_rd),
    .ctx_load(ctx_load), .save_ctx(save_ctx), .op_done(op_done), .ctx_rd(ctx_rd),
    .evt_status(evt_status), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  // Expected outputs, written from the requirements
  function automatic logic exp_irq(input logic [3:0] s, input logic [3:0] e, input logic [9:0] c);
    logic hit;
    hit = 0;
    for (int b = 0; b < 4; b++) begin
      logic ev;
      ev = s[b];
      if (c[9] && b == 2) ev = s[2] | s[3];
      if (c[9] && b == 3) ev = 0;
      if (ev && e[b]) hit = 1;
    end
    return hit;
  endfunction

  function automatic logic [3:0] exp_dma(input logic [3:0] s, input logic [9:0] c);
    logic [3:0] r;
    r[0] = s[1] & c[5];
    r[1] = (c[9] ? (s[2] | s[3]) : s[2]) & c[6];
    r[2] = s[0] & c[7];
    r[3] = c[9] ? 1'b0 : (s[3] & c[8]);
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step();
    do_reset(); step();
    // R1
    check("R1 status", evt_status, 4'b0011);
    check("R1 en", en_rdata, 0);
    check("R1 cfg", cfg_rdata, 0);
    check("R1 irq", irq, 0);
    check("R1 dma", dma_req, 0);

    // R6 input buffer handshake
    blk_wr = 1; step(); blk_wr = 0;
    check("R6 write clears", evt_status[1], 0);
    blk_wr = 1; core_take = 1; step(); blk_wr = 0; core_take = 0;
    check("R6 write wins", evt_status[1], 0);
    core_take = 1; step(); core_take = 0;
    check("R6 take sets", evt_status[1], 1);
    core_take = 1; step(); core_take = 0;
    check("R6 take when empty", evt_status[1], 1);

    // R7 output handshake
    core_out = 1; step(); core_out = 0;
    check("R7 produce", evt_status[2], 1);
    core_out = 1; blk_rd = 1; step(); core_out = 0; blk_rd = 0;
    check("R7 produce wins", evt_status[2], 1);
    blk_rd = 1; step(); blk_rd = 0;
    check("R7 read clears", evt_status[2], 0);

    // R11 stray context pulses while idle
    op_done = 1; step(); op_done = 0;
    check("R11 done idle", evt_status, 4'b0011);
    ctx_rd = 1; step(); ctx_rd = 0;
    check("R11 rd idle", evt_status, 4'b0011);

    // R8 plain operation; R11 load while busy not sampled
    ctx_load = 1; save_ctx = 0; step(); ctx_load = 0;
    check("R8 load busy", evt_status, 4'b0010);
    ctx_load = 1; save_ctx = 1; step(); ctx_load = 0; save_ctx = 0;
    check("R11 load busy", evt_status, 4'b0010);
    ctx_rd = 1; step(); ctx_rd = 0;
    check("R11 rd busy", evt_status, 4'b0010);
    op_done = 1; step(); op_done = 0;
    check("R8 R11 done no save", evt_status, 4'b0011);

    // R8 saved operation; R2 status bit 3
    ctx_load = 1; save_ctx = 1; step(); ctx_load = 0; save_ctx = 0;
    op_done = 1; step(); op_done = 0;
    check("R8 R2 saved", evt_status, 4'b1010);
    ctx_load = 1; step(); ctx_load = 0;
    check("R11 load saved", evt_status, 4'b1010);
    ctx_rd = 1; step(); ctx_rd = 0;
    check("R8 collect", evt_status, 4'b0011);

    // R10 readback masking
    cfg_we = 1; cfg_wdata = 10'h3FF; step(); cfg_we = 0;
    check("R10 cfg keep", cfg_rdata, 10'h3E0);
    cfg_we = 1; cfg_wdata = 10'h01F; step(); cfg_we = 0;
    check("R10 cfg low", cfg_rdata, 10'h000);

    // Sweep: 12 flag states x 16 masks x 32 configs; R2 R3 R4 R5
    for (int s = 0; s < 12; s++) begin
      int ctxs;
      logic fin, fout;
      logic [3:0] es;
      ctxs = s % 3; fin = s[2]; fout = s[3];
      if (s >= 6) begin fout = 1; fin = ((s - 6) / 3) != 0; end
      else begin fout = 0; fin = (s / 3) != 0; end
      do_reset();
      if (fin)  begin blk_wr = 1; step(); blk_wr = 0; end
      if (fout) begin core_out = 1; step(); core_out = 0; end
      if (ctxs != 0) begin
        ctx_load = 1; save_ctx = (ctxs == 2); step(); ctx_load = 0; save_ctx = 0;
        if (ctxs == 2) begin op_done = 1; step(); op_done = 0; end
      end
      es = {ctxs == 2, fout, ~fin, ctxs == 0};
      check("R2 status", evt_status, es);
      for (int e = 0; e < 16; e++) begin
        for (int c = 0; c < 32; c++) begin
          logic [9:0] cv;
          cv = 10'(c << 5);
          en_we = 1; en_wdata = 4'(e); cfg_we = 1; cfg_wdata = cv;
          step(); en_we = 0; cfg_we = 0;
          check(cv[9] ? "R5 irq" : "R3 irq", irq, exp_irq(es, 4'(e), cv));
          check(cv[9] ? "R5 dma" : "R4 dma", dma_req, exp_dma(es, cv));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule